// File: doc/BRIEF.md
# TDD Switching Signal Generator

This block produces the uplink/downlink switching waveform for a time-division repeater. An upstream detector reports where it found a frame boundary with a one-cycle strobe, together with a mode code that selects the downlink share of the frame. The block does not switch at that strobe. It schedules the next downlink start a programmed delay later, so that the switching edge meets the frame boundary after the RF path. That delay is one frame period less the excess of the digital-path latency over the RF-path latency, and less the latency of the generation stage itself.

After the first scheduled start, a 5000-tick phase counter runs the frame on its own. Every later boundary strobe re-anchors that counter. All timing is counted in 1 µs ticks taken from a clock prescaler, so the adjustment step is one tick. The three latency values sit in registers behind a small write port. The power-amplifier enable stays low until switching has actually started. It drops again at once when the upstream analyser withdraws its mode. The block only has control pins; no stream interface is involved.

Top module: `tdd_sync_gen`

## Requirements
- R1: After reset `tdd_dl` is 1 and `pa_en` is 0. The latency registers hold their defaults: digital 50, RF 6, generation 2, which gives a delay of 4954 ticks.
- R2: The first downlink start comes D ticks after the tick on which the strobe is taken, with D = 5000 − (digital − RF) − generation. On that tick `pa_en` rises with `tdd_dl` at 1.
- R3: D is clamped to the range 1 to 4999 ticks. A larger computed value gives 4999 and a smaller one gives 1.
- R4: Each frame starts with `tdd_dl` at 1 for a number of ticks set by the mode code: 0 gives 3539, 1 gives 3193, 2 gives 2848. `tdd_dl` is 0 for the rest of the 5000-tick frame.
- R5: With no further strobes, the generator repeats the frame every 5000 ticks.
- R6: A strobe that arrives while switching is running restarts the schedule, so the next start comes D ticks after that strobe. The old schedule is dropped and `pa_en` stays high.
- R7: A change of mode code takes effect at the next frame start. The frame in progress keeps its downlink length.
- R8: Until the first scheduled start, `pa_en` is 0 and `tdd_dl` is 1, and this holds on the tick just before the start.
- R9: When `mode_ok` is 0, or the mode code is 3, the next cycle shows `pa_en` at 0 and `tdd_dl` at 1. Strobes seen in that condition are discarded.
- R10: A write with `cfg_we` sets the digital latency at address 0, the RF latency at address 1 and the generation latency at address 2. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | One-cycle pulse marking a detected frame boundary |
| mode_code | input | 2 | Downlink share selector (0, 1, 2; 3 is invalid) |
| mode_ok | input | 1 | Analyser reports a valid signal and mode |
| cfg_we | input | 1 | Latency register write enable |
| cfg_addr | input | 2 | Latency register select |
| cfg_wdata | input | LAT_W | Latency value in ticks |
| tdd_dl | output | 1 | Switching output, 1 for downlink |
| pa_en | output | 1 | Power-amplifier enable |

## Verification
The checks assume that `frame_strobe` is a pulse on a single clock edge. They assume that the digital latency is not below the RF latency, and that a tick occurs on every cycle in the bench configuration. Frame-length and fall-position properties are stated only for ticks without a re-anchoring strobe, because a strobe may legitimately make the phase jump. The stimulus follows these rules: it drives one-edge strobes from the falling clock edge, it rewrites the latency registers only while the generator is idle, and it sets the prescaler to one cycle per tick. With those settings, every expected edge falls on a known falling-edge sample counted from the strobe.

// File: rtl/tdd_sync_pkg.sv
package tdd_sync_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ARMED = 2'd1,
    GS_RUN   = 2'd2
  } gen_state_e;

  localparam logic [1:0] MODE_BAD = 2'd3;

  // downlink length in ticks for each mode code
  function automatic int unsigned dl_ticks(input logic [1:0] code);
    case (code)
      2'd0:    dl_ticks = 3539;
      2'd1:    dl_ticks = 3193;
      2'd2:    dl_ticks = 2848;
      default: dl_ticks = 0;
    endcase
  endfunction

endpackage

// File: rtl/tdd_tick_gen.sv
module tdd_tick_gen #(
  parameter int CYC_PER_TICK = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CYC_PER_TICK <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CYC_PER_TICK);
      localparam logic [DW-1:0] LASTC = DW'(CYC_PER_TICK - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LASTC) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == LASTC);
    end
  endgenerate
endmodule

// File: rtl/tdd_lat_regs.sv
module tdd_lat_regs #(
  parameter int LAT_W   = 13,
  parameter int CNT_W   = 13,
  parameter int PERIOD  = 5000,
  parameter int DIG_RST = 50,
  parameter int RF_RST  = 6,
  parameter int GEN_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [LAT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] dly_o
);
  localparam int SW = ((LAT_W > CNT_W) ? LAT_W : CNT_W) + 3;
  localparam logic signed [SW-1:0] PER_S = SW'(PERIOD);
  localparam logic signed [SW-1:0] MAX_S = SW'(PERIOD - 1);
  localparam logic signed [SW-1:0] MIN_S = SW'(1);

  logic [LAT_W-1:0] dig_q, rf_q, gen_q;
  logic signed [SW-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= LAT_W'(DIG_RST);
      rf_q  <= LAT_W'(RF_RST);
      gen_q <= LAT_W'(GEN_RST);
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    dig_q <= cfg_wdata;
        2'd1:    rf_q  <= cfg_wdata;
        2'd2:    gen_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // period minus net pipeline latency minus generation latency
  assign raw = PER_S - $signed(SW'(dig_q)) + $signed(SW'(rf_q)) - $signed(SW'(gen_q));

  always_comb begin
    if (raw < MIN_S)      dly_o = CNT_W'(1);
    else if (raw > MAX_S) dly_o = CNT_W'(PERIOD - 1);
    else                  dly_o = raw[CNT_W-1:0];
  end

  // R10
  bad_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd3) |=> $stable(dly_o));
endmodule

// File: rtl/tdd_frame_core.sv
module tdd_frame_core import tdd_sync_pkg::*; #(
  parameter int PERIOD = 5000,
  parameter int CNT_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             strobe_i,
  input  logic [1:0]       mode_i,
  input  logic             mode_ok_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             tdd_dl_o,
  output logic             pa_en_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] PER  = CNT_W'(PERIOD);

  gen_state_e       st_q;
  logic [CNT_W-1:0] ph_q, len_q;
  logic             pend_q;
  logic             vld, realign;

  assign vld     = mode_ok_i && (mode_i != MODE_BAD);
  assign realign = vld && tick_i && (pend_q || strobe_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_IDLE;
      ph_q   <= '0;
      len_q  <= '0;
      pend_q <= 1'b0;
    end else if (!vld) begin
      st_q   <= GS_IDLE;
      pend_q <= 1'b0;
    end else if (tick_i) begin
      pend_q <= 1'b0;
      if (pend_q || strobe_i) begin
        ph_q <= PER - dly_i;
        if (st_q == GS_IDLE) st_q <= GS_ARMED;
      end else if (st_q != GS_IDLE) begin
        if (ph_q == LAST) begin
          ph_q  <= '0;
          len_q <= CNT_W'(dl_ticks(mode_i));
          st_q  <= GS_RUN;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end else if (strobe_i) begin
      pend_q <= 1'b1;
    end
  end

  assign pa_en_o  = (st_q == GS_RUN);
  assign tdd_dl_o = (st_q != GS_RUN) || (ph_q < len_q);

  // R5
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PER);
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && tick_i && !realign && st_q == GS_RUN && ph_q == LAST) |=> (ph_q == '0 && tdd_dl_o));
  // R8
  pa_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_en_o) |-> (ph_q == '0 && tdd_dl_o));
  // R4
  dl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tdd_dl_o) && !$past(realign)) |-> (pa_en_o && ph_q == len_q));
  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> (!pa_en_o && tdd_dl_o));
endmodule

// File: rtl/tdd_sync_gen.sv
module tdd_sync_gen #(
  parameter int CYC_PER_TICK = 100,
  parameter int PERIOD_TICKS = 5000,
  parameter int LAT_W        = 13,
  parameter int DIG_LAT_RST  = 50,
  parameter int RF_LAT_RST   = 6,
  parameter int GEN_LAT_RST  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_strobe,
  input  logic [1:0]       mode_code,
  input  logic             mode_ok,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [LAT_W-1:0] cfg_wdata,
  output logic             tdd_dl,
  output logic             pa_en
);
  localparam int CNT_W = $clog2(PERIOD_TICKS + 1);

  logic             tick;
  logic [CNT_W-1:0] dly;

  tdd_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  tdd_lat_regs #(
    .LAT_W(LAT_W), .CNT_W(CNT_W), .PERIOD(PERIOD_TICKS),
    .DIG_RST(DIG_LAT_RST), .RF_RST(RF_LAT_RST), .GEN_RST(GEN_LAT_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dly_o(dly)
  );

  tdd_frame_core #(.PERIOD(PERIOD_TICKS), .CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .strobe_i(frame_strobe),
    .mode_i(mode_code), .mode_ok_i(mode_ok), .dly_i(dly),
    .tdd_dl_o(tdd_dl), .pa_en_o(pa_en)
  );
endmodule

// File: tb/tdd_sync_gen_tb_top.sv
module tdd_sync_gen_tb_top;
  localparam int P = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_strobe = 1'b0;
  logic [1:0]  mode_code = 2'd0;
  logic        mode_ok = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [12:0] cfg_wdata = '0;
  logic        tdd_dl, pa_en;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdd_sync_gen #(.CYC_PER_TICK(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .mode_code(mode_code), .mode_ok(mode_ok), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tdd_dl(tdd_dl), .pa_en(pa_en)
  );

  typedef struct packed {
    int mode; int dig; int rf; int gen; int exp_d; int exp_len;
  } vec_t;

  // R2 rows, R3 clamp rows (index 3 high, index 4 low), R4 lengths per mode
  localparam vec_t VECS [6] = '{
    '{0, 50,   6,   2,    4954, 3539},
    '{1, 100,  10,  10,   4900, 3193},
    '{2, 44,   5,   0,    4961, 2848},
    '{0, 10,   10,  0,    4999, 3539},
    '{1, 4000, 0,   2000, 1,    3193},
    '{2, 300,  100, 700,  4100, 2848}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at tick %0d: actual %0b expected %0b", req, pos, act, exp);
    end
  endtask

  task automatic adv(input int tgt);
    while (pos < tgt) begin
      @(negedge clk);
      pos++;
    end
  endtask

  task automatic pulse();
    frame_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_strobe = 1'b0;
    pos = 0;
  endtask

  task automatic go_idle();
    mode_ok = 1'b0;
    @(negedge clk);
    mode_ok = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 13'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame_chk(input string req, input int d, input int len);
    adv(d - 1); chk("R8 pa before start", pa_en, 1'b0); chk("R8 dl before start", tdd_dl, 1'b1);
    adv(d);     chk({req, " pa at start"}, pa_en, 1'b1); chk({req, " dl at start"}, tdd_dl, 1'b1);
    adv(d + len - 1); chk("R4 last dl tick", tdd_dl, 1'b1);
    adv(d + len);     chk("R4 first ul tick", tdd_dl, 1'b0);
    adv(d + P - 1);   chk("R5 end of frame", tdd_dl, 1'b0);
    adv(d + P);       chk("R5 next frame start", tdd_dl, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pa after reset", pa_en, 1'b0);
    chk("R1 dl after reset", tdd_dl, 1'b1);
    // R1 default latencies give 4954
    mode_code = 2'd0;
    pulse();
    frame_chk("R1", 4954, 3539);

    foreach (VECS[i]) begin
      go_idle();
      mode_code = 2'(VECS[i].mode);
      wr(2'd0, VECS[i].dig);
      wr(2'd1, VECS[i].rf);
      wr(2'd2, VECS[i].gen);
      pulse();
      frame_chk((i == 3 || i == 4) ? "R3" : "R2", VECS[i].exp_d, VECS[i].exp_len);
    end

    // R6 re-anchor mid-frame
    go_idle();
    mode_code = 2'd0;
    wr(2'd0, 50); wr(2'd1, 6); wr(2'd2, 2);
    pulse();
    adv(4954); chk("R2 start", pa_en, 1'b1);
    adv(4954 + 100);
    pulse();
    chk("R6 pa kept", pa_en, 1'b1);
    adv(4900); chk("R6 old start dropped", tdd_dl, 1'b0);
    adv(4953); chk("R6 before new start", tdd_dl, 1'b0);
    adv(4954); chk("R6 new start", tdd_dl, 1'b1); chk("R6 pa", pa_en, 1'b1);

    // R7 mode change deferred to next frame
    adv(4964); mode_code = 2'd2;
    adv(4954 + 3000); chk("R7 current frame keeps length", tdd_dl, 1'b1);
    adv(4954 + P); chk("R7 next start", tdd_dl, 1'b1);
    adv(4954 + P + 2847); chk("R7 new length last dl", tdd_dl, 1'b1);
    adv(4954 + P + 2848); chk("R7 new length ul", tdd_dl, 1'b0);

    // R9 loss of valid mode
    mode_ok = 1'b0;
    adv(pos + 1);
    chk("R9 pa off", pa_en, 1'b0); chk("R9 dl forced", tdd_dl, 1'b1);
    pulse();
    mode_ok = 1'b1;
    adv(4954 + 10); chk("R9 strobe ignored while invalid", pa_en, 1'b0);
    mode_code = 2'd3;
    pulse();
    adv(4954 + 5); chk("R9 code 3 pa", pa_en, 1'b0); chk("R9 code 3 dl", tdd_dl, 1'b1);
    mode_code = 2'd0;
    @(negedge clk);

    // R10 address 3 write has no effect
    wr(2'd3, 1000);
    pulse();
    adv(4953); chk("R10 before start", pa_en, 1'b0);
    adv(4954); chk("R10 start unchanged", pa_en, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule